// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Retry Controller

This block decides what happens to a frame whose transmission meets a collision on a shared half-duplex medium. The transmit datapath tells it when an attempt starts, when an attempt ends cleanly, when a collision is seen and how many bytes of the attempt had gone out at that moment. The controller answers with an abort request for the current attempt. It then either waits a random backoff and asks for a retransmission, or gives up on the frame and asks for the next one. When a frame is finished it posts one status word: the number of collisions, whether the retry limit was hit, and whether any late collision occurred.

Two configuration bits shape the policy. The single-attempt bit cuts the retry limit from sixteen attempts to one. The late-retransmit bit selects whether a collision after the 64-byte window drops the frame or is retried like any other collision. A duplex bit turns the whole collision path off for full-duplex links. The random wait is a truncated binary exponential backoff: after the n-th collision the wait is r slot times, with r drawn from a free-running LFSR in the range 0 to 2^min(n,10)-1. One slot lasts SLOT_CYCLES clock cycles.

All pins are plain control and status strobes. There is no data stream and no back-pressure. Each request and each status strobe is a one-cycle pulse, and the status fields hold their value until the next status pulse.

Top module: `txretry_ctrl`

## Requirements
- R1: After reset, retx_req, abort_req, next_req, stat_valid and backoff_busy are all 0.
- R2: When eof is sampled during an active attempt with no collision in the same cycle, stat_valid and next_req pulse together in the next cycle with stat_retry_err=0 and stat_coll_cnt equal to the number of collisions the frame met.
- R3: With half_duplex=1, a collision sampled during an active attempt raises abort_req for exactly one cycle, in the next cycle.
- R4: When a collision leads to a retry, backoff_busy rises together with abort_req, and retx_req pulses exactly backoff_slots*SLOT_CYCLES+1 cycles after abort_req.
- R5: With no_retry=0, the 16th collision of a frame ends it: stat_valid and next_req pulse with stat_retry_err=1 and stat_coll_cnt=16, and no backoff starts.
- R6: With no_retry=1, the first non-dropped collision ends the frame: stat_retry_err=1, stat_coll_cnt=1, next_req pulses and no backoff starts.
- R7: With late_retx=0, a collision with byte_cnt >= 64 ends the frame with stat_late_coll=1, stat_retry_err=0 and a next_req pulse.
- R8: With late_retx=1, a late collision is retried with a backoff, and the frame's final status reports stat_late_coll=1.
- R9: With half_duplex=0, collisions are ignored: no abort_req, and the final status counts 0 collisions.
- R10: A collision at byte_cnt=63 is early: it is retried under late_retx=0, and the status reports stat_late_coll=0.
- R11: After the n-th collision of a frame, backoff_slots is at most 2^min(n,10)-1.
- R12: While no attempt is active, coll and eof produce no abort_req, no stat_valid and no next_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | First attempt of a new frame begins (pulse) |
| eof | input | 1 | Current attempt finished without collision (pulse) |
| coll | input | 1 | Collision seen on the medium (pulse) |
| byte_cnt | input | BYTE_W | Bytes of the current attempt sent so far |
| half_duplex | input | 1 | 1 = half duplex, collision handling active |
| no_retry | input | 1 | 1 = single attempt per frame |
| late_retx | input | 1 | 1 = retry after late collisions, 0 = drop |
| retx_req | output | 1 | Start the retransmission now (pulse) |
| abort_req | output | 1 | Stop the current attempt (pulse) |
| next_req | output | 1 | Move on to the next frame (pulse) |
| backoff_busy | output | 1 | Backoff wait in progress |
| backoff_slots | output | BACKOFF_CAP | Slot count of the current backoff |
| stat_valid | output | 1 | Frame status valid (pulse) |
| stat_retry_err | output | 1 | Retry limit reached |
| stat_late_coll | output | 1 | A late collision occurred in the frame |
| stat_coll_cnt | output | $clog2(MAX_ATTEMPTS+1) | Collisions seen by the frame |

## Verification
Abort, status and next-frame pulses are due in the cycle right after the one in which coll or eof was sampled. The retransmit pulse is due backoff_slots*SLOT_CYCLES+1 cycles after the abort pulse. The bench changes inputs on the falling clock edge and reads outputs on the next falling edge, so each pulse is caught in the cycle it is due. For retries it reads the drawn slot count at the port and counts falling edges until retx_req, which must equal the count computed from that slot value. It uses a short slot time so that sixteen backoffs fit in the run.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    TXR_IDLE = 2'd0,
    TXR_SEND = 2'd1,
    TXR_WAIT = 2'd2
  } txr_state_e;
endpackage

// File: rtl/txr_lfsr.sv
// Free-running Fibonacci LFSR; exposes its low OUT_W bits as a random draw.
module txr_lfsr #(
  parameter int             W     = 16,
  parameter int             OUT_W = 10,
  parameter logic [W-1:0]   TAPS  = 16'hB400,
  parameter logic [W-1:0]   SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] value
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & TAPS);
  assign value = state_q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {state_q[W-2:0], fb};
  end
endmodule

// File: rtl/txr_backoff.sv
// Counts a loaded number of slots, each SLOT_CYC cycles, then pulses done.
module txr_backoff #(
  parameter int SLOT_W   = 10,
  parameter int SLOT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] slots,
  output logic              busy,
  output logic [SLOT_W-1:0] slots_q,
  output logic              done
);
  localparam int CYC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(SLOT_CYC - 1);

  logic [SLOT_W-1:0] left_q;
  logic [CYC_W-1:0]  cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      slots_q <= '0;
      left_q  <= '0;
      cyc_q   <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy    <= 1'b1;
        slots_q <= slots;
        left_q  <= slots;
        cyc_q   <= CYC_TOP;
      end else if (busy) begin
        if (left_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (cyc_q == '0) begin
          left_q <= left_q - 1'b1;
          cyc_q  <= CYC_TOP;
        end else begin
          cyc_q <= cyc_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/txr_core.sv
// Attempt tracking and retry/drop decision.
module txr_core
  import txr_pkg::*;
#(
  parameter int MAX_ATT    = 16,
  parameter int BO_CAP     = 10,
  parameter int LATE_BYTES = 64,
  parameter int BYTE_W     = 11,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eof,
  input  logic              coll,
  input  logic [BYTE_W-1:0] byte_cnt,
  input  logic              half_duplex,
  input  logic              no_retry,
  input  logic              late_retx,
  input  logic              bo_done,
  input  logic [BO_CAP-1:0] rnd,
  output logic              bo_load,
  output logic [BO_CAP-1:0] bo_slots,
  output logic              abort_req,
  output logic              next_req,
  output logic              stat_valid,
  output logic              stat_retry_err,
  output logic              stat_late_coll,
  output logic [CNT_W-1:0]  stat_coll_cnt
);
  txr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             late_q;

  logic             coll_hit, is_late, late_drop, limit_drop;
  logic [CNT_W-1:0] cnt_nxt, k;
  logic [BO_CAP:0]  mask_w;

  always_comb begin
    coll_hit   = (state_q == TXR_SEND) && coll && half_duplex;
    is_late    = byte_cnt >= BYTE_W'(LATE_BYTES);
    cnt_nxt    = cnt_q + 1'b1;
    late_drop  = coll_hit && is_late && !late_retx;
    limit_drop = coll_hit && !late_drop && (no_retry || (cnt_nxt >= CNT_W'(MAX_ATT)));
    bo_load    = coll_hit && !late_drop && !limit_drop;
    k          = (cnt_nxt > CNT_W'(BO_CAP)) ? CNT_W'(BO_CAP) : cnt_nxt;
    mask_w     = ((BO_CAP+1)'(1) << k) - 1'b1;
    bo_slots   = rnd & mask_w[BO_CAP-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= TXR_IDLE;
      cnt_q          <= '0;
      late_q         <= 1'b0;
      abort_req      <= 1'b0;
      next_req       <= 1'b0;
      stat_valid     <= 1'b0;
      stat_retry_err <= 1'b0;
      stat_late_coll <= 1'b0;
      stat_coll_cnt  <= '0;
    end else begin
      abort_req  <= 1'b0;
      next_req   <= 1'b0;
      stat_valid <= 1'b0;
      unique case (state_q)
        TXR_IDLE: begin
          if (sof) begin
            state_q <= TXR_SEND;
            cnt_q   <= '0;
            late_q  <= 1'b0;
          end
        end
        TXR_SEND: begin
          if (coll_hit) begin
            abort_req <= 1'b1;
            cnt_q     <= cnt_nxt;
            late_q    <= late_q | is_late;
            if (bo_load) begin
              state_q <= TXR_WAIT;
            end else begin
              state_q        <= TXR_IDLE;
              next_req       <= 1'b1;
              stat_valid     <= 1'b1;
              stat_retry_err <= limit_drop;
              stat_late_coll <= late_q | is_late;
              stat_coll_cnt  <= cnt_nxt;
            end
          end else if (eof) begin
            state_q        <= TXR_IDLE;
            next_req       <= 1'b1;
            stat_valid     <= 1'b1;
            stat_retry_err <= 1'b0;
            stat_late_coll <= late_q;
            stat_coll_cnt  <= cnt_q;
          end
        end
        TXR_WAIT: begin
          if (bo_done) state_q <= TXR_SEND;
        end
        default: state_q <= TXR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl #(
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          BACKOFF_CAP  = 10,
  parameter int          LATE_BYTES   = 64,
  parameter int          BYTE_W       = 11,
  parameter int          SLOT_CYCLES  = 64,
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_TAPS    = 16'hB400,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sof,
  input  logic                                 eof,
  input  logic                                 coll,
  input  logic [BYTE_W-1:0]                    byte_cnt,
  input  logic                                 half_duplex,
  input  logic                                 no_retry,
  input  logic                                 late_retx,
  output logic                                 retx_req,
  output logic                                 abort_req,
  output logic                                 next_req,
  output logic                                 backoff_busy,
  output logic [BACKOFF_CAP-1:0]               backoff_slots,
  output logic                                 stat_valid,
  output logic                                 stat_retry_err,
  output logic                                 stat_late_coll,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0]    stat_coll_cnt
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);

  logic [BACKOFF_CAP-1:0] rnd, bo_slots;
  logic                   bo_load, bo_done;

  txr_lfsr #(
    .W(LFSR_W), .OUT_W(BACKOFF_CAP),
    .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_SEED[LFSR_W-1:0])
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .value(rnd)
  );

  txr_core #(
    .MAX_ATT(MAX_ATTEMPTS), .BO_CAP(BACKOFF_CAP), .LATE_BYTES(LATE_BYTES),
    .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .coll(coll),
    .byte_cnt(byte_cnt), .half_duplex(half_duplex), .no_retry(no_retry),
    .late_retx(late_retx), .bo_done(bo_done), .rnd(rnd),
    .bo_load(bo_load), .bo_slots(bo_slots), .abort_req(abort_req),
    .next_req(next_req), .stat_valid(stat_valid),
    .stat_retry_err(stat_retry_err), .stat_late_coll(stat_late_coll),
    .stat_coll_cnt(stat_coll_cnt)
  );

  txr_backoff #(
    .SLOT_W(BACKOFF_CAP), .SLOT_CYC(SLOT_CYCLES)
  ) u_backoff (
    .clk(clk), .rst_n(rst_n), .load(bo_load), .slots(bo_slots),
    .busy(backoff_busy), .slots_q(backoff_slots), .done(bo_done)
  );

  assign retx_req = bo_done;
endmodule

// File: rtl/txretry_ctrl_chk.sv
module txretry_ctrl_chk #(
  parameter int MAX_ATT = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_duplex,
  input logic             no_retry,
  input logic             retx_req,
  input logic             abort_req,
  input logic             next_req,
  input logic             backoff_busy,
  input logic             stat_valid,
  input logic             stat_retry_err,
  input logic [CNT_W-1:0] stat_coll_cnt
);
  AST_FD_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex |=> !abort_req); // R9
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req); // R3
  AST_RETX_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> $past(backoff_busy)); // R4
  AST_NEXT_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |-> stat_valid); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_coll_cnt <= CNT_W'(MAX_ATT))); // R5
  AST_NO_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backoff_busy) |-> !$past(no_retry)); // R6
  AST_RETRY_ERR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_retry_err) |-> abort_req); // R6
  AST_RETX_NOT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !(retx_req && next_req)); // R5
endmodule

bind txretry_ctrl txretry_ctrl_chk #(
  .MAX_ATT(MAX_ATTEMPTS), .CNT_W($clog2(MAX_ATTEMPTS + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .no_retry(no_retry),
  .retx_req(retx_req), .abort_req(abort_req), .next_req(next_req),
  .backoff_busy(backoff_busy), .stat_valid(stat_valid),
  .stat_retry_err(stat_retry_err), .stat_coll_cnt(stat_coll_cnt)
);

// File: tb/tb_txretry_ctrl.sv
module tb_txretry_ctrl;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 0, eof = 0, coll = 0;
  logic [10:0] byte_cnt = '0;
  logic        half_duplex = 1, no_retry = 0, late_retx = 0;
  logic        retx_req, abort_req, next_req, backoff_busy;
  logic [9:0]  backoff_slots;
  logic        stat_valid, stat_retry_err, stat_late_coll;
  logic [4:0]  stat_coll_cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  txretry_ctrl #(.SLOT_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .coll(coll),
    .byte_cnt(byte_cnt), .half_duplex(half_duplex), .no_retry(no_retry),
    .late_retx(late_retx), .retx_req(retx_req), .abort_req(abort_req),
    .next_req(next_req), .backoff_busy(backoff_busy),
    .backoff_slots(backoff_slots), .stat_valid(stat_valid),
    .stat_retry_err(stat_retry_err), .stat_late_coll(stat_late_coll),
    .stat_coll_cnt(stat_coll_cnt)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
  endtask

  task automatic end_frame();
    @(negedge clk); eof = 1;
    @(negedge clk); eof = 0;
  endtask

  task automatic hit(int bytes);
    @(negedge clk); coll = 1; byte_cnt = 11'(bytes);
    @(negedge clk); coll = 0; byte_cnt = '0;
  endtask

  // Called at the falling edge where abort_req is visible after the n-th collision.
  task automatic wait_retx(int n, string req);
    int r = int'(backoff_slots);
    int k = (n > 10) ? 10 : n;
    int w = 0;
    check("R11", "backoff_slots within range", int'(r <= (1 << k) - 1), 1);
    check(req, "backoff_busy on retry", int'(backoff_busy), 1);
    while (retx_req !== 1'b1 && w < 5000) begin
      @(negedge clk); w++;
    end
    check("R4", "cycles from abort to retx", w, r * S + 1);
  endtask

  task automatic t_reset();
    check("R1", "retx_req", int'(retx_req), 0);
    check("R1", "abort_req", int'(abort_req), 0);
    check("R1", "next_req", int'(next_req), 0);
    check("R1", "stat_valid", int'(stat_valid), 0);
    check("R1", "backoff_busy", int'(backoff_busy), 0);
  endtask

  task automatic t_idle_ignore();
    half_duplex = 1;
    hit(10);
    check("R12", "abort while idle", int'(abort_req), 0);
    end_frame();
    check("R12", "status while idle", int'(stat_valid), 0);
    check("R12", "next while idle", int'(next_req), 0);
  endtask

  task automatic t_clean();
    start_frame();
    repeat (5) @(negedge clk);
    end_frame();
    check("R2", "stat_valid", int'(stat_valid), 1);
    check("R2", "next_req", int'(next_req), 1);
    check("R2", "retry_err", int'(stat_retry_err), 0);
    check("R2", "coll_cnt", int'(stat_coll_cnt), 0);
    @(negedge clk);
    check("R2", "stat_valid one cycle", int'(stat_valid), 0);
  endtask

  task automatic t_full_duplex();
    half_duplex = 0;
    start_frame();
    hit(20);
    check("R9", "abort in full duplex", int'(abort_req), 0);
    check("R9", "busy in full duplex", int'(backoff_busy), 0);
    end_frame();
    check("R9", "coll_cnt", int'(stat_coll_cnt), 0);
    half_duplex = 1;
  endtask

  task automatic t_retry_ok();
    start_frame();
    for (int i = 1; i <= 3; i++) begin
      hit(10 * i);
      check("R3", "abort pulse", int'(abort_req), 1);
      check("R3", "no status on retry", int'(stat_valid), 0);
      wait_retx(i, "R4");
    end
    end_frame();
    check("R2", "stat_valid after retries", int'(stat_valid), 1);
    check("R2", "coll_cnt after retries", int'(stat_coll_cnt), 3);
    check("R2", "retry_err after retries", int'(stat_retry_err), 0);
  endtask

  task automatic t_limit();
    start_frame();
    for (int i = 1; i <= 15; i++) begin
      hit(30);
      wait_retx(i, "R5");
    end
    hit(30);
    check("R5", "stat_valid at limit", int'(stat_valid), 1);
    check("R5", "retry_err at limit", int'(stat_retry_err), 1);
    check("R5", "coll_cnt at limit", int'(stat_coll_cnt), 16);
    check("R5", "next_req at limit", int'(next_req), 1);
    check("R5", "no backoff at limit", int'(backoff_busy), 0);
  endtask

  task automatic t_single();
    no_retry = 1;
    start_frame();
    hit(12);
    check("R6", "abort", int'(abort_req), 1);
    check("R6", "stat_valid", int'(stat_valid), 1);
    check("R6", "retry_err", int'(stat_retry_err), 1);
    check("R6", "coll_cnt", int'(stat_coll_cnt), 1);
    check("R6", "next_req", int'(next_req), 1);
    check("R6", "no backoff", int'(backoff_busy), 0);
    no_retry = 0;
  endtask

  task automatic t_late_edge();
    late_retx = 0;
    start_frame();
    hit(63);
    check("R10", "byte 63 is retried", int'(backoff_busy), 1);
    wait_retx(1, "R10");
    end_frame();
    check("R10", "late flag after byte 63", int'(stat_late_coll), 0);
    start_frame();
    hit(64);
    check("R7", "stat_valid late drop", int'(stat_valid), 1);
    check("R7", "late flag", int'(stat_late_coll), 1);
    check("R7", "retry_err", int'(stat_retry_err), 0);
    check("R7", "next_req", int'(next_req), 1);
    check("R7", "no backoff", int'(backoff_busy), 0);
  endtask

  task automatic t_late_retx();
    late_retx = 1;
    start_frame();
    hit(200);
    check("R8", "abort", int'(abort_req), 1);
    check("R8", "no status", int'(stat_valid), 0);
    wait_retx(1, "R8");
    end_frame();
    check("R8", "stat_valid", int'(stat_valid), 1);
    check("R8", "late flag", int'(stat_late_coll), 1);
    check("R8", "coll_cnt", int'(stat_coll_cnt), 1);
    late_retx = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle_ignore();
    t_clean();
    t_full_duplex();
    t_retry_ok();
    t_single();
    t_late_edge();
    t_late_retx();
    t_limit();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        summary();
      end
    end
  end
endmodule